// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the arithmetic and logic datapath of a small processor core. It takes two operands and an operation code and returns the result in the same cycle, working either on the low byte or on the full 16-bit word as the width input selects. It also holds six status flags in a register. When an operation is presented with its valid strobe, the register updates on the next clock edge according to that operation's own flag rule.

The two carry-chaining operations take their carry or borrow input from the stored carry flag. This lets software build wide arithmetic out of a sequence of word operations. Compare works like a subtraction, but it tells the surrounding logic through a write-enable output that its result must not be stored. Increment and decrement leave the stored carry untouched. Complement and byte-to-word extension leave every flag untouched.

Top module: `word_alu`

## Requirements
- R1: After a synchronous active-high reset, `flags` is all zero. While `op_valid` is low, `flags` keeps its value. `flags` bit order is {OF,SF,ZF,PF,AF,CF}, from bit 5 down to bit 0.
- R2: Code 0 (add) returns a+b. Code 1 (add with carry) returns a+b+CF. CF is set when the unsigned sum does not fit the selected width.
- R3: Code 2 (subtract) returns a-b. Code 3 (subtract with borrow) returns a-b-CF. CF is set when the subtraction borrows out of the selected width.
- R4: Code 4 (compare) updates the flags exactly as code 2 does, and drives `res_wr` low. `res_wr` is also low for the unused code 15, which returns 0 and changes no flag. `res_wr` is high for every other code.
- R5: Code 5 (increment, a+1) and code 6 (decrement, a-1) ignore `opnd_b`. They set AF, OF, PF, ZF and SF and keep the previous CF.
- R6: Code 7 (negate) returns 0-a. CF is set exactly when a is nonzero at the selected width.
- R7: Codes 8, 9 and 10 (AND, OR, XOR) clear CF, AF and OF.
- R8: Code 11 (complement) returns the bitwise inverse of a and leaves all six flags unchanged.
- R9: Code 12 shifts a left by one and code 13 shifts it right by one, filling with zero. CF receives the bit shifted out and AF is cleared. For a left shift, OF is the new top bit XOR CF. For a right shift, OF is the original top bit.
- R10: Code 14 returns bit 7 of a replicated into bits 15..8, above a[7:0], whatever the width input says. It leaves the flags unchanged.
- R11: PF is set when result bits 7..0 hold an even number of ones, in both widths. ZF is set when the result is zero at the selected width. SF copies bit 7 (byte) or bit 15 (word) of the result.
- R12: For arithmetic codes, AF is the carry or borrow between bit 3 and bit 4. OF is set when the signed result falls outside the range of the selected width.
- R13: With `is_word` low, bits 15..8 of `result` are zero for every code except 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Apply this operation's flag rule at the next edge |
| op_sel | input | 4 | Operation code |
| is_word | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Combinational result |
| res_wr | output | 1 | Result should be written back |
| flags | output | 6 | Stored flags {OF,SF,ZF,PF,AF,CF} |

## Verification
Directed patterns come first. They sit on the edges where flags are decided: all-ones plus one and 7F plus one in each width, zero minus one, 80 negated in a byte, and a chained add-with-carry after a carry-producing add. Each one separates carry from overflow, or byte limits from word limits. Words whose low byte has odd parity but whose high byte does not show whether parity looks only at the low byte. Sequences that set CF and then increment show whether the stored carry is kept. A long random stream of mixed codes, widths and valid strobes then runs against a behavioural model that carries its own flag state. This catches any flag that drifts from the model over chained operations.

// File: rtl/walu_pkg.sv
package walu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NEG = 4'd7,
        OP_AND = 4'd8,
        OP_OR  = 4'd9,
        OP_XOR = 4'd10,
        OP_NOT = 4'd11,
        OP_SHL = 4'd12,
        OP_SHR = 4'd13,
        OP_SXT = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        UPD_ALL,
        UPD_KEEP_CF,
        UPD_NONE
    } flag_upd_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic aux;
        logic cry;
    } alu_flags_t;

    typedef struct packed {
        logic      use_arith;
        logic      sub;
        logic      zero_x;
        logic      one_y;
        logic      cin_from_cf;
        flag_upd_e upd;
        logic      wr;
    } alu_ctrl_t;

    function automatic logic even_ones8(input logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic alu_ctrl_t decode_op(input alu_op_e op);
        alu_ctrl_t c;
        c = '{use_arith: 1'b0, sub: 1'b0, zero_x: 1'b0, one_y: 1'b0,
              cin_from_cf: 1'b0, upd: UPD_ALL, wr: 1'b1};
        case (op)
            OP_ADD: c.use_arith = 1'b1;
            OP_ADC: begin c.use_arith = 1'b1; c.cin_from_cf = 1'b1; end
            OP_SUB: begin c.use_arith = 1'b1; c.sub = 1'b1; end
            OP_SBB: begin c.use_arith = 1'b1; c.sub = 1'b1; c.cin_from_cf = 1'b1; end
            OP_CMP: begin c.use_arith = 1'b1; c.sub = 1'b1; c.wr = 1'b0; end
            OP_INC: begin c.use_arith = 1'b1; c.one_y = 1'b1; c.upd = UPD_KEEP_CF; end
            OP_DEC: begin c.use_arith = 1'b1; c.sub = 1'b1; c.one_y = 1'b1; c.upd = UPD_KEEP_CF; end
            OP_NEG: begin c.use_arith = 1'b1; c.sub = 1'b1; c.zero_x = 1'b1; end
            OP_NOT: c.upd = UPD_NONE;
            OP_SXT: c.upd = UPD_NONE;
            OP_NOP: begin c.upd = UPD_NONE; c.wr = 1'b0; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    input  logic          sub,
    input  logic          is_word,
    output logic [DW-1:0] sum,
    output logic          cry,
    output logic          aux,
    output logic          ovf
);
    localparam int HW = DW / 2;

    logic [DW-1:0] yy;
    logic          cc;
    logic [DW:0]   wsum;
    logic [HW:0]   bsum;
    logic          co, xm, ym, rm;

    always_comb begin
        yy   = sub ? ~y : y;
        cc   = sub ? ~cin : cin;
        wsum = {1'b0, x} + {1'b0, yy} + {{DW{1'b0}}, cc};
        bsum = {1'b0, x[HW-1:0]} + {1'b0, yy[HW-1:0]} + {{HW{1'b0}}, cc};
        sum  = is_word ? wsum[DW-1:0] : {{HW{1'b0}}, bsum[HW-1:0]};
        co   = is_word ? wsum[DW] : bsum[HW];
        cry  = co ^ sub;
        aux  = x[4] ^ yy[4] ^ wsum[4] ^ sub;
        xm   = is_word ? x[DW-1]  : x[HW-1];
        ym   = is_word ? yy[DW-1] : yy[HW-1];
        rm   = is_word ? wsum[DW-1] : bsum[HW-1];
        ovf  = (xm == ym) && (rm != xm);
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import walu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_word,
    output logic [DW-1:0] res,
    output logic          cry,
    output logic          ovf
);
    localparam int HW = DW / 2;

    logic [DW-1:0] wmask, am, bm;
    logic          top_a;

    always_comb begin
        wmask = is_word ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
        am    = a & wmask;
        bm    = b & wmask;
        top_a = is_word ? a[DW-1] : a[HW-1];
        res   = '0;
        cry   = 1'b0;
        ovf   = 1'b0;
        case (op)
            OP_AND: res = am & bm;
            OP_OR:  res = am | bm;
            OP_XOR: res = am ^ bm;
            OP_NOT: res = ~am & wmask;
            OP_SHL: begin
                res = (am << 1) & wmask;
                cry = top_a;
                ovf = (is_word ? res[DW-1] : res[HW-1]) ^ top_a;
            end
            OP_SHR: begin
                res = am >> 1;
                cry = a[0];
                ovf = top_a;
            end
            OP_SXT: res = {{HW{a[HW-1]}}, a[HW-1:0]};
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
    import walu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] res,
    input  logic          is_word,
    input  logic          cry,
    input  logic          aux,
    input  logic          ovf,
    output alu_flags_t    fl
);
    localparam int HW = DW / 2;

    always_comb begin
        fl.cry = cry;
        fl.aux = aux;
        fl.ovf = ovf;
        fl.par = even_ones8(res[7:0]);
        fl.zro = is_word ? (res == '0) : (res[HW-1:0] == '0);
        fl.sgn = is_word ? res[DW-1] : res[HW-1];
    end

endmodule

// File: rtl/word_alu.sv
module word_alu
    import walu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic          is_word,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] result,
    output logic          res_wr,
    output logic [5:0]    flags
);
    localparam int HW = DW / 2;

    alu_op_e    op;
    alu_ctrl_t  ctl;
    alu_flags_t flags_q, flags_n, eval_fl;

    logic [DW-1:0] ax, ay, asum, lres;
    logic          acin, acry, aaux, aovf, lcry, lovf;
    logic          sel_cry, sel_aux, sel_ovf;

    assign op  = alu_op_e'(op_sel);
    assign ctl = decode_op(op);

    always_comb begin
        ax   = ctl.zero_x ? '0 : opnd_a;
        ay   = ctl.zero_x ? opnd_a : (ctl.one_y ? {{(DW-1){1'b0}}, 1'b1} : opnd_b);
        acin = ctl.cin_from_cf ? flags_q.cry : 1'b0;
    end

    alu_addsub #(.DW(DW)) u_addsub (
        .x(ax), .y(ay), .cin(acin), .sub(ctl.sub), .is_word(is_word),
        .sum(asum), .cry(acry), .aux(aaux), .ovf(aovf)
    );

    alu_logic #(.DW(DW)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .is_word(is_word),
        .res(lres), .cry(lcry), .ovf(lovf)
    );

    always_comb begin
        result  = ctl.use_arith ? asum : lres;
        sel_cry = ctl.use_arith ? acry : lcry;
        sel_aux = ctl.use_arith ? aaux : 1'b0;
        sel_ovf = ctl.use_arith ? aovf : lovf;
        res_wr  = ctl.wr;
    end

    alu_flag_eval #(.DW(DW)) u_flags (
        .res(result), .is_word(is_word), .cry(sel_cry), .aux(sel_aux),
        .ovf(sel_ovf), .fl(eval_fl)
    );

    always_comb begin
        flags_n = flags_q;
        if (op_valid) begin
            case (ctl.upd)
                UPD_ALL:     flags_n = eval_fl;
                UPD_KEEP_CF: begin flags_n = eval_fl; flags_n.cry = flags_q.cry; end
                default:     flags_n = flags_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_n;
    end

    assign flags = flags_q;

    // R1: flags hold while no operation is applied
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(flags));

    // R4: compare never requests a write-back
    p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd4) |-> !res_wr);

    // R5: increment and decrement preserve the stored carry
    p_incdec_cf_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 4'd5 || op_sel == 4'd6)) |=> (flags[0] == $past(flags[0])));

    // R7: logical operations leave CF, AF and OF cleared
    p_logic_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 4'd8 || op_sel == 4'd9 || op_sel == 4'd10))
        |=> (flags[0] == 1'b0 && flags[1] == 1'b0 && flags[5] == 1'b0));

    // R8: complement touches no flag
    p_not_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd11) |=> $stable(flags));

    // R11: a zero result cannot also be negative
    p_zf_sf_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(flags[3] && flags[4]));

    // R13: byte results keep the upper byte clear
    p_byte_upper_r13: assert property (@(posedge clk) disable iff (rst)
        (!is_word && op_sel != 4'd14) |-> (result[DW-1:HW] == '0));

endmodule

// File: tb/test_word_alu.sv
`timescale 1ns/1ps
module test_word_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic        is_word;
    logic [15:0] opnd_a, opnd_b;
    logic [15:0] result;
    logic        res_wr;
    logic [5:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [5:0] mflags;
    bit finished = 0;

    always #2 clk = ~clk;

    word_alu i_word_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .res_wr(res_wr), .flags(flags)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:         return "R2";
            4'd2, 4'd3:         return "R3";
            4'd4, 4'd15:        return "R4";
            4'd5, 4'd6:         return "R5";
            4'd7:               return "R6";
            4'd8, 4'd9, 4'd10:  return "R7";
            4'd11:              return "R8";
            4'd12, 4'd13:       return "R9";
            default:            return "R10";
        endcase
    endfunction

    function automatic int sgn(input int v, input int half);
        return (v >= half) ? v - 2 * half : v;
    endfunction

    // behavioural model: returns result, next flags, write-enable
    task automatic model(input logic [3:0] op, input logic w, input logic [15:0] a,
                         input logic [15:0] b, input logic [5:0] fin,
                         output logic [15:0] r, output logic [5:0] fo, output logic wr);
        int mask, half, msb, av, bv, c0, s, ss, rr;
        logic cf, af, of, keep_cf, touch;
        mask = w ? 65535 : 255;
        half = w ? 32768 : 128;
        msb  = w ? 15 : 7;
        av = a & mask; bv = b & mask;
        cf = 0; af = 0; of = 0; keep_cf = 0; touch = 1; wr = 1; rr = 0;
        case (op)
            4'd0, 4'd1, 4'd5: begin
                c0 = (op == 4'd1) ? int'(fin[0]) : 0;
                if (op == 4'd5) begin bv = 1; keep_cf = 1; end
                s = av + bv + c0; rr = s & mask; cf = (s > mask);
                af = ((av & 15) + (bv & 15) + c0) > 15;
                ss = sgn(av, half) + sgn(bv, half) + c0;
                of = (ss >= half) || (ss < -half);
            end
            4'd2, 4'd3, 4'd4, 4'd6, 4'd7: begin
                c0 = (op == 4'd3) ? int'(fin[0]) : 0;
                if (op == 4'd6) begin bv = 1; keep_cf = 1; end
                if (op == 4'd7) begin bv = av; av = 0; end
                if (op == 4'd4) wr = 0;
                s = av - bv - c0; rr = s & mask; cf = (s < 0);
                af = ((av & 15) - (bv & 15) - c0) < 0;
                ss = sgn(av, half) - sgn(bv, half) - c0;
                of = (ss >= half) || (ss < -half);
            end
            4'd8:  rr = av & bv;
            4'd9:  rr = av | bv;
            4'd10: rr = av ^ bv;
            4'd11: begin rr = ~av & mask; touch = 0; end
            4'd12: begin
                rr = (av << 1) & mask; cf = (av >> msb) & 1;
                of = ((rr >> msb) & 1) ^ cf;
            end
            4'd13: begin
                rr = av >> 1; cf = av & 1; of = (av >> msb) & 1;
            end
            4'd14: begin
                rr = a[7] ? (32'hFF00 | a[7:0]) : a[7:0]; touch = 0;
            end
            default: begin rr = 0; wr = 0; touch = 0; end
        endcase
        r = rr[15:0];
        if (!touch) fo = fin;
        else begin
            fo[0] = keep_cf ? fin[0] : cf;
            fo[1] = af;
            fo[2] = ~(^r[7:0]);
            fo[3] = (rr == 0);
            fo[4] = (rr >> msb) & 1;
            fo[5] = of;
        end
    endtask

    // drive at negedge, compare combinational outputs, then apply edge
    task automatic step(input logic v, input logic [3:0] op, input logic w,
                        input logic [15:0] a, input logic [15:0] b);
        logic [15:0] er; logic [5:0] ef; logic ewr; string rq;
        @(negedge clk);
        check("R1", "flags", {10'd0, flags}, {10'd0, mflags});
        op_valid = v; op_sel = op; is_word = w; opnd_a = a; opnd_b = b;
        #1;
        model(op, w, a, b, mflags, er, ef, ewr);
        rq = req_of(op);
        check(rq, "result", result, er);
        check("R4", "res_wr", {15'd0, res_wr}, {15'd0, ewr});
        if (v) mflags = ef;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; op_valid = 0; op_sel = 0; is_word = 1; opnd_a = 0; opnd_b = 0;
        mflags = 6'h3F;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        mflags = 6'h00;
        check("R1", "reset flags", {10'd0, flags}, 16'h0000);

        // R2 word carry-out to zero, then chained add with carry
        step(1, 4'd0, 1, 16'hFFFF, 16'h0001);
        step(1, 4'd1, 1, 16'h1234, 16'h0000);
        // R12 byte signed overflow and auxiliary carry
        step(1, 4'd0, 0, 16'h007F, 16'h0001);
        // R3 borrow from zero, then subtract with borrow
        step(1, 4'd2, 1, 16'h0000, 16'h0001);
        step(1, 4'd3, 1, 16'h0010, 16'h0001);
        // R4 compare, then code 15
        step(1, 4'd4, 0, 16'h0005, 16'h0009);
        step(1, 4'd15, 1, 16'hABCD, 16'h1111);
        // R5 carry kept through increment and decrement
        step(1, 4'd2, 0, 16'h0001, 16'h0002);
        step(1, 4'd5, 0, 16'h00FF, 16'h5555);
        step(1, 4'd6, 1, 16'h8000, 16'h0000);
        // R6 negate of zero and of the most negative byte
        step(1, 4'd7, 0, 16'h0000, 16'h0000);
        step(1, 4'd7, 0, 16'h0080, 16'h0000);
        // R7 logic after carry set
        step(1, 4'd0, 1, 16'hFFFF, 16'hFFFF);
        step(1, 4'd10, 1, 16'h0F0F, 16'h00F0);
        // R8 complement keeps flags; R11 odd low byte with even high byte
        step(1, 4'd11, 1, 16'h1234, 16'h0000);
        step(1, 4'd9, 1, 16'h0301, 16'h0000);
        // R9 shifts in byte mode
        step(1, 4'd12, 0, 16'h00C0, 16'h0000);
        step(1, 4'd13, 0, 16'h0081, 16'h0000);
        // R10 sign extension ignores width
        step(1, 4'd14, 0, 16'h3385, 16'h0000);
        step(1, 4'd14, 1, 16'hFF7A, 16'h0000);
        // R1 no update without valid
        step(0, 4'd0, 1, 16'hFFFF, 16'h0001);
        // R13 byte upper clear under mixed patterns
        step(1, 4'd8, 0, 16'hFFFF, 16'hFFFF);

        for (int i = 0; i < 4000; i++)
            step(($urandom % 8) != 0, 4'($urandom % 16), 1'($urandom % 2),
                 16'($urandom), 16'($urandom));

        @(negedge clk);
        check("R1", "final flags", {10'd0, flags}, {10'd0, mflags});
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule